// File: doc/BRIEF.md
# Pipeline Operand Interlock

This block decides, cycle by cycle, whether the instruction waiting in the issue stage of an in-order pipeline may move on into E1. The pipeline stages are I1, I2, E1, E2, E3 and E4. Each source operand of the waiting instruction carries a flag that says whether the operand is first used in E1 or only in E2. The block compares each source register with the destinations of the instructions it has issued in the last few cycles. Each of those destinations carries a producer kind, which tells in which stage its value can first be forwarded. When the issue distance to the youngest matching producer is still too short, the block raises `stall`. The waiting instruction then stays where it is and a bubble goes into E1.

The block also enforces two occupancy rules. A multiply keeps E1 busy for a second cycle. A divide keeps E2 busy for a number of cycles that depends on the bit length of its dividend. While either unit is busy, nothing may issue. A pipeline flush empties all tracking and all occupancy in the cycle it is raised.

The datapath, the forwarding multiplexers and instruction decode live elsewhere. Decode supplies the register numbers, the need-stage flags and the producer kind.

Top module: `opnd_interlock`

## Requirements
- R1: `issue_go` equals `iss_valid & ~stall & ~flush`. `stall` is never high while `iss_valid` is low or `flush` is high.
- R2: `dst_kind` 0 (result ready at the end of E2) feeding a source with `src_late`=0 (needed in E1) needs an issue distance of 2 cycles, so one stall cycle when the consumer directly follows. A source with `src_late`=1 (needed in E2) never stalls on it.
- R3: `dst_kind` 1 or 3 (single load, or last word of a load-multiple, data ready in E3) needs an issue distance of 3 cycles to an E1 source and 2 cycles to an E2 source.
- R4: `dst_kind` 2 (second-to-last word of a load-multiple) needs an issue distance of 2 cycles to an E1 source and never stalls an E2 source.
- R5: Each source uses its own `src_late` flag. When the accumulator source is needed in E2, its dependency on a kind-0 producer adds no stall, while a multiplicand source needed in E1 does stall.
- R6: Register 0, a source with `src_vld` low, and a producer with `dst_vld` low never form a dependency.
- R7: Only instructions that actually issue are tracked. The issue distance counts from the cycle in which `issue_go` was high, and a stalled cycle records nothing.
- R8: While `flush` is high, `stall` and `issue_go` are low. From the next cycle on, no instruction issued before the flush causes a stall.
- R9: After an instruction issues with `iss_mul` high, the next cycle is blocked for every instruction, and the cycle after that is free.
- R10: After an instruction issues with `iss_div` high, issue is blocked for L+1 cycles. L is the bit length of the dividend's magnitude (0 to 32), with `div_operand` read as two's complement.
- R11: A flush ends any multiply or divide occupancy in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush; clears all tracking |
| iss_valid | input | 1 | An instruction waits in the issue stage |
| src_vld | input | NUM_SRC | Per-source valid |
| src_reg | input | NUM_SRC*REG_W | Source register numbers, source k at bits k*REG_W |
| src_late | input | NUM_SRC | Per source: 1 = needed in E2, 0 = needed in E1 |
| dst_vld | input | 1 | Waiting instruction writes a register |
| dst_reg | input | REG_W | Destination register number |
| dst_kind | input | 2 | Producer kind: 0 E2-ready, 1/3 load, 2 second-to-last load-multiple word |
| iss_mul | input | 1 | Waiting instruction uses the multiplier |
| iss_div | input | 1 | Waiting instruction uses the divider |
| div_operand | input | DATA_W | Dividend of a divide, two's complement |
| stall | output | 1 | Hold the waiting instruction and insert a bubble into E1 |
| issue_go | output | 1 | Waiting instruction moves into E1 this cycle |

## Verification
The tracked history lasts only two cycles. A wrong destination, kind or valid bit in it therefore shows at the ports as a stall that is one or two cycles too long or too short, on the very next dependent instruction. A wrong divider count can stay hidden longer, up to 34 cycles. It shows up as the cycle in which `issue_go` first returns after a divide, so every divide scenario checks each blocked cycle and the exact release cycle.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    KIND_E2_READY = 2'd0,
    KIND_LOAD     = 2'd1,
    KIND_LMW_PEN  = 2'd2,
    KIND_LOAD_ALT = 2'd3
  } prod_kind_e;

  // longest issue distance of any producer/consumer pair
  localparam int MAX_DIST = 3;

  // issue distance needed between a producer of kind k and a consumer
  // operand first used in E2 (late = 1) or in E1 (late = 0)
  function automatic int need_dist(input prod_kind_e k, input logic late);
    int d;
    case (k)
      KIND_E2_READY, KIND_LMW_PEN: d = late ? 1 : 2;
      default:                     d = late ? 2 : MAX_DIST;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ilk_history.sv
module ilk_history
  import ilk_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_vld,
  input  logic [REG_W-1:0] push_dst,
  input  prod_kind_e       push_kind,
  output logic [DEPTH-1:0] slot_vld,
  output logic [REG_W-1:0] slot_dst  [DEPTH],
  output prod_kind_e       slot_kind [DEPTH]
);

  // slot i holds the instruction issued i+1 cycles ago
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
          slot_vld[0]  <= 1'b0;
          slot_dst[0]  <= '0;
          slot_kind[0] <= KIND_E2_READY;
        end else begin
          slot_vld[0]  <= push_vld;
          slot_dst[0]  <= push_dst;
          slot_kind[0] <= push_kind;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
          slot_vld[i]  <= 1'b0;
          slot_dst[i]  <= '0;
          slot_kind[i] <= KIND_E2_READY;
        end else begin
          slot_vld[i]  <= slot_vld[i-1];
          slot_dst[i]  <= slot_dst[i-1];
          slot_kind[i] <= slot_kind[i-1];
        end
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_vld == '0)); // R8

endmodule

// File: rtl/ilk_match.sv
module ilk_match
  import ilk_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int DEPTH = 2
) (
  input  logic             src_vld,
  input  logic [REG_W-1:0] src_reg,
  input  logic             src_late,
  input  logic [DEPTH-1:0] slot_vld,
  input  logic [REG_W-1:0] slot_dst  [DEPTH],
  input  prod_kind_e       slot_kind [DEPTH],
  output logic             hazard
);

  logic src_live;
  assign src_live = src_vld && (src_reg != '0);

  // a match is a hazard while its age (slot index + 1) is below the distance
  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (src_live && slot_vld[i] && (slot_dst[i] == src_reg) &&
          ((i + 1) < need_dist(slot_kind[i], src_late)))
        hazard = 1'b1;
    end
  end

endmodule

// File: rtl/ilk_struct.sv
module ilk_struct #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue_go,
  input  logic              iss_mul,
  input  logic              iss_div,
  input  logic [DATA_W-1:0] div_operand,
  output logic              struct_block
);

  localparam int CNT_W = $clog2(DATA_W + 3);

  // cycles the divider holds E2: bit length of |dividend| plus two
  function automatic int div_hold(input logic [DATA_W-1:0] a);
    logic [DATA_W-1:0] mag;
    int len;
    mag = a[DATA_W-1] ? (~a + DATA_W'(1)) : a;
    len = 0;
    for (int i = 0; i < DATA_W; i++)
      if (mag[i]) len = i + 1;
    return len + 2;
  endfunction

  logic             mul_block;
  logic [CNT_W-1:0] div_cnt;
  logic             div_busy;

  assign div_busy     = (div_cnt != '0);
  assign struct_block = mul_block | div_busy;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      mul_block <= 1'b0;
      div_cnt   <= '0;
    end else begin
      mul_block <= issue_go & iss_mul;
      if (issue_go && iss_div)
        div_cnt <= CNT_W'(div_hold(div_operand) - 1);
      else if (div_busy)
        div_cnt <= div_cnt - CNT_W'(1);
    end
  end

  AST_MUL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mul_block |=> !mul_block); // R9
  AST_DIV_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !flush) |=> (div_cnt == $past(div_cnt) - CNT_W'(1))); // R10
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= CNT_W'(DATA_W + 1)); // R10
  AST_FLUSH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !struct_block); // R11

endmodule

// File: rtl/opnd_interlock.sv
module opnd_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 3,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     iss_valid,
  input  logic [NUM_SRC-1:0]       src_vld,
  input  logic [NUM_SRC*REG_W-1:0] src_reg,
  input  logic [NUM_SRC-1:0]       src_late,
  input  logic                     dst_vld,
  input  logic [REG_W-1:0]         dst_reg,
  input  logic [1:0]               dst_kind,
  input  logic                     iss_mul,
  input  logic                     iss_div,
  input  logic [DATA_W-1:0]        div_operand,
  output logic                     stall,
  output logic                     issue_go
);

  localparam int DEPTH = MAX_DIST - 1;

  logic [DEPTH-1:0]   slot_vld;
  logic [REG_W-1:0]   slot_dst  [DEPTH];
  prod_kind_e         slot_kind [DEPTH];
  logic [NUM_SRC-1:0] src_haz;
  logic               raw_hazard;
  logic               struct_block;
  logic               push_vld;

  assign push_vld = issue_go && dst_vld && (dst_reg != '0);

  ilk_history #(.REG_W(REG_W), .DEPTH(DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_vld  (push_vld),
    .push_dst  (dst_reg),
    .push_kind (prod_kind_e'(dst_kind)),
    .slot_vld  (slot_vld),
    .slot_dst  (slot_dst),
    .slot_kind (slot_kind)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ilk_match #(.REG_W(REG_W), .DEPTH(DEPTH)) u_match (
      .src_vld   (src_vld[g]),
      .src_reg   (src_reg[g*REG_W +: REG_W]),
      .src_late  (src_late[g]),
      .slot_vld  (slot_vld),
      .slot_dst  (slot_dst),
      .slot_kind (slot_kind),
      .hazard    (src_haz[g])
    );
  end

  ilk_struct #(.DATA_W(DATA_W)) u_struct (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .issue_go     (issue_go),
    .iss_mul      (iss_mul),
    .iss_div      (iss_div),
    .div_operand  (div_operand),
    .struct_block (struct_block)
  );

  assign raw_hazard = |src_haz;
  assign stall      = iss_valid & ~flush & (raw_hazard | struct_block);
  assign issue_go   = iss_valid & ~flush & ~raw_hazard & ~struct_block;

  AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue_go); // R1
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!stall && !issue_go)); // R8

endmodule

// File: tb/tb_opnd_interlock.sv
`timescale 1ns/1ps
module tb_opnd_interlock;
  localparam int RW = 5;
  localparam int NS = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n, flush, iss_valid, dst_vld, iss_mul, iss_div;
  logic [NS-1:0] src_vld, src_late;
  logic [NS*RW-1:0] src_reg;
  logic [RW-1:0] dst_reg;
  logic [1:0] dst_kind;
  logic [DW-1:0] div_operand;
  logic stall, issue_go;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  opnd_interlock #(.REG_W(RW), .NUM_SRC(NS), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .src_vld(src_vld), .src_reg(src_reg), .src_late(src_late),
    .dst_vld(dst_vld), .dst_reg(dst_reg), .dst_kind(dst_kind),
    .iss_mul(iss_mul), .iss_div(iss_div), .div_operand(div_operand),
    .stall(stall), .issue_go(issue_go));

  task automatic idle();
    flush = 0; iss_valid = 0; src_vld = '0; src_reg = '0; src_late = '0;
    dst_vld = 0; dst_reg = '0; dst_kind = 2'd0;
    iss_mul = 0; iss_div = 0; div_operand = '0;
  endtask

  task automatic use_src(int k, int r, bit late);
    src_vld[k] = 1'b1; src_reg[k*RW +: RW] = RW'(r); src_late[k] = late;
  endtask

  task automatic put_dst(int r, int kind);
    dst_vld = 1'b1; dst_reg = RW'(r); dst_kind = 2'(kind);
  endtask

  // inputs are set 1 ns after a rising edge; outputs checked 1 ns later
  task automatic chk(bit exp_stall, string tag);
    logic exp_go;
    exp_go = iss_valid & ~exp_stall & ~flush;
    #1;
    checks++;
    if (stall !== exp_stall || issue_go !== exp_go) begin
      errors++;
      $display("FAIL %s: stall=%0b issue_go=%0b expected stall=%0b issue_go=%0b",
               tag, stall, issue_go, exp_stall, exp_go);
    end
    @(posedge clk); #1;
  endtask

  task automatic gap();
    for (int i = 0; i < 3; i++) begin idle(); chk(0, "R1 idle"); end
  endtask

  task automatic t_reset();
    idle(); chk(0, "R1 reset");
    idle(); iss_valid = 1; chk(0, "R1 free issue");
    gap();
  endtask

  task automatic t_e2_ready();
    idle(); iss_valid = 1; put_dst(4, 0); chk(0, "R2 producer");
    idle(); iss_valid = 1; use_src(0, 4, 0); chk(1, "R2 E1 consumer age1");
    idle(); iss_valid = 1; use_src(0, 4, 0); chk(0, "R2 E1 consumer age2");
    gap();
    idle(); iss_valid = 1; put_dst(4, 0); chk(0, "R2 producer");
    idle(); iss_valid = 1; use_src(2, 4, 1); chk(0, "R2 E2 consumer");
    gap();
  endtask

  task automatic t_load();
    idle(); iss_valid = 1; put_dst(9, 1); chk(0, "R3 load");
    idle(); iss_valid = 1; use_src(1, 9, 0); chk(1, "R3 E1 age1");
    idle(); iss_valid = 1; use_src(1, 9, 0); chk(1, "R3 E1 age2");
    idle(); iss_valid = 1; use_src(1, 9, 0); chk(0, "R3 E1 age3");
    gap();
    idle(); iss_valid = 1; put_dst(9, 3); chk(0, "R3 load kind3");
    idle(); iss_valid = 1; use_src(0, 9, 1); chk(1, "R3 E2 age1");
    idle(); iss_valid = 1; use_src(0, 9, 1); chk(0, "R3 E2 age2");
    gap();
  endtask

  task automatic t_penult();
    idle(); iss_valid = 1; put_dst(3, 2); chk(0, "R4 producer");
    idle(); iss_valid = 1; use_src(0, 3, 0); chk(1, "R4 E1 age1");
    idle(); iss_valid = 1; use_src(0, 3, 0); chk(0, "R4 E1 age2");
    gap();
    idle(); iss_valid = 1; put_dst(3, 2); chk(0, "R4 producer");
    idle(); iss_valid = 1; use_src(0, 3, 1); chk(0, "R4 E2 age1");
    gap();
  endtask

  task automatic t_mac();
    idle(); iss_valid = 1; put_dst(6, 0); chk(0, "R5 producer");
    idle(); iss_valid = 1; use_src(0, 6, 1); use_src(1, 7, 0); use_src(2, 8, 0);
    chk(0, "R5 accumulator late");
    gap();
    idle(); iss_valid = 1; put_dst(6, 0); chk(0, "R5 producer");
    idle(); iss_valid = 1; use_src(0, 2, 1); use_src(1, 6, 0); chk(1, "R5 multiplicand early");
    idle(); iss_valid = 1; use_src(0, 2, 1); use_src(1, 6, 0); chk(0, "R5 release");
    gap();
  endtask

  task automatic t_zero();
    idle(); iss_valid = 1; put_dst(0, 1); chk(0, "R6 r0 producer");
    idle(); iss_valid = 1; use_src(0, 0, 0); chk(0, "R6 r0 source");
    gap();
    idle(); iss_valid = 1; dst_reg = 5'd8; dst_kind = 2'd1; chk(0, "R6 no dst");
    idle(); iss_valid = 1; use_src(0, 8, 0); chk(0, "R6 invalid dst ignored");
    gap();
    idle(); iss_valid = 1; put_dst(8, 1); chk(0, "R6 producer");
    idle(); iss_valid = 1; src_reg[RW-1:0] = 5'd8; chk(0, "R6 invalid src ignored");
    gap();
  endtask

  task automatic t_bubble();
    idle(); iss_valid = 1; put_dst(5, 1); chk(0, "R7 load");
    idle(); iss_valid = 1; use_src(0, 5, 1); put_dst(7, 1); chk(1, "R7 stalled");
    idle(); iss_valid = 1; use_src(0, 5, 1); put_dst(7, 1); chk(0, "R7 issued");
    idle(); iss_valid = 1; use_src(0, 7, 1); chk(1, "R7 distance from real issue");
    idle(); iss_valid = 1; use_src(0, 7, 1); chk(0, "R7 release");
    gap();
  endtask

  task automatic t_flush();
    idle(); iss_valid = 1; put_dst(5, 1); chk(0, "R8 load");
    idle(); iss_valid = 1; use_src(0, 5, 0); flush = 1; chk(0, "R8 during flush");
    idle(); iss_valid = 1; use_src(0, 5, 0); chk(0, "R8 after flush");
    gap();
    idle(); iss_valid = 1; iss_div = 1; div_operand = 32'd100; chk(0, "R11 div");
    idle(); iss_valid = 1; flush = 1; chk(0, "R11 flush");
    idle(); iss_valid = 1; chk(0, "R11 divider freed");
    idle(); iss_valid = 1; iss_mul = 1; chk(0, "R11 mul");
    idle(); iss_valid = 1; flush = 1; chk(0, "R11 flush");
    idle(); iss_valid = 1; chk(0, "R11 multiplier freed");
    gap();
  endtask

  task automatic t_mul();
    idle(); iss_valid = 1; iss_mul = 1; chk(0, "R9 mul");
    idle(); iss_valid = 1; chk(1, "R9 second E1 cycle");
    idle(); iss_valid = 1; chk(0, "R9 free");
    idle(); iss_valid = 1; chk(0, "R9 still free");
    gap();
  endtask

  task automatic t_div(logic [DW-1:0] a, int bitlen);
    idle(); iss_valid = 1; iss_div = 1; div_operand = a; chk(0, "R10 div");
    for (int i = 0; i < bitlen + 1; i++) begin
      idle(); iss_valid = 1; chk(1, "R10 divider busy");
    end
    idle(); iss_valid = 1; chk(0, "R10 divider release");
    gap();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_e2_ready();
    t_load();
    t_penult();
    t_mac();
    t_zero();
    t_bubble();
    t_flush();
    t_mul();
    t_div(32'd5, 3);
    t_div(32'd0, 0);
    t_div(-32'sd6, 3);
    t_div(32'h8000_0000, 32);
    t_div(32'h7FFF_FFFF, 31);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule